// File: doc/BRIEF.md
# UART Xon/Xoff Flow Controller

This block gives a UART automatic software flow control and detection of a special received character. It compares the receive FIFO fill count with a programmable threshold. When the count climbs above the threshold it asks the transmitter to insert a two-character "stop" pair (Xoff1, Xoff2). When the count later falls below the threshold it asks for a two-character "resume" pair (Xon1, Xon2). A count equal to the threshold is a dead band, so a level that hovers at the threshold does not make the pairs chatter.

Inserted characters are offered on a request/character/acknowledge handshake. The transmitter keeps its normal data waiting while the request is high. Both characters of a pair go out back to back and nothing breaks into them. The block also compares every received character with the Xoff2 value. Only the bits inside the programmed word length take part, and bit 0 of the register is aligned with the character's LSB. A match raises a sticky flag that a read of the interrupt status clears. The serializer, the deserializer and the FIFO storage are outside this block.

Top module: `xonxoff_flow_ctrl`

## Requirements
- R1: While rst_n is low and in the first cycle after it, ins_req and special_flag are 0.
- R2: Flow control is active when flow_en=1 and special_en=0. While it is active and idle, an rx_level strictly greater than trig_level raises ins_req in the next cycle. The pair offers the Xoff1 value, then the Xoff2 value, and each character is held on ins_char until a cycle with ins_ack=1.
- R3: After an Xoff pair has completed, an rx_level strictly below trig_level while flow control is active starts an Xon pair: the Xon1 value, then the Xon2 value, on the same handshake.
- R4: An Xoff pair is sent only once per upward crossing. While the level stays above the threshold or equal to it, no further pair is requested. A level equal to trig_level starts no pair in either direction.
- R5: Once ins_req has risen it stays high, with the first character stable, until acknowledged. The second character follows at once. Changes to rx_level, flow_en or special_en during the pair do not shorten or interrupt it.
- R6: With flow_en=0 or special_en=1 no pair is started. If flow control is turned off after an Xoff pair, the block returns to idle and sends no Xon pair.
- R7: The character compare uses only the low bits selected by wlen (00=5, 01=6, 10=7, 11=8 bits). Bit 0 of xoff2_char is compared with bit 0 of rx_char, and bits above the word length are ignored.
- R8: A match received while special_en=1 sets special_flag in the next cycle. The flag stays set until a cycle with isr_read=1 and reads 0 in the next cycle. When a match and isr_read come in the same cycle, the flag ends up set.
- R9: With special_en=0 a received character never sets special_flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flow_en | input | 1 | Enables automatic Xon/Xoff insertion |
| special_en | input | 1 | Enables special-character detection; also suppresses insertion |
| wlen | input | 2 | Word length: 00=5, 01=6, 10=7, 11=8 bits |
| trig_level | input | LVL_W | Receive FIFO threshold |
| rx_level | input | LVL_W | Current receive FIFO fill count |
| xon1_char | input | 8 | First resume character |
| xon2_char | input | 8 | Second resume character |
| xoff1_char | input | 8 | First stop character |
| xoff2_char | input | 8 | Second stop character and compare value |
| rx_valid | input | 1 | One-cycle strobe for a received character |
| rx_char | input | 8 | Received character, LSB in bit 0 |
| isr_read | input | 1 | Host reads interrupt status; clears special_flag |
| ins_ack | input | 1 | Transmitter takes the offered character |
| ins_req | output | 1 | A flow-control character is offered |
| ins_char | output | 8 | Offered flow-control character |
| special_flag | output | 1 | Sticky special-character detected |

## Verification
The hardest situation to reach is a pair in flight while its own cause goes away. The stimulus holds ins_ack low after the Xoff request rises. It then drops the FIFO level to zero and turns flow control off, and checks that the first character stays offered and that both characters still go out. With the block now in its Xoff-sent state and flow control off, the bench re-enables flow control with the level still low. It checks that no Xon pair appears, which shows that the disable returned the block to idle. The word-length mask is checked with characters that differ from Xoff2 only above the active width, and with one that differs inside it.

// File: rtl/xfc_pkg.sv
// Package: shared types and helpers for the Xon/Xoff flow controller.
// Assumes 8-bit character registers; word length selects 5..8 active bits.
package xfc_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_FIRST  = 2'd1,
        SEQ_SECOND = 2'd2,
        SEQ_OFF    = 2'd3
    } seq_state_t;

    typedef enum logic {
        PAIR_XON  = 1'b0,
        PAIR_XOFF = 1'b1
    } pair_kind_t;

    // Mask of active character bits: 00->5, 01->6, 10->7, 11->8 bits
    function automatic logic [CHAR_W-1:0] word_mask(input logic [1:0] wl);
        logic [1:0] drop;
        drop = 2'd3 - wl;
        return {CHAR_W{1'b1}} >> drop;
    endfunction

endpackage

// File: rtl/xfc_level_cmp.sv
// Module: threshold comparator with a dead band at equality.
// Assumes level and threshold are unsigned counts of equal width.
module xfc_level_cmp #(
    parameter int LVL_W = 6
) (
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] thresh,
    output logic             above,
    output logic             below
);
    // Strict comparisons leave level == thresh as a hold band
    always_comb begin
        above = (level > thresh);
        below = (level < thresh);
    end
endmodule

// File: rtl/xfc_char_match.sv
// Module: compares each received character with the compare value under
// the word-length mask and keeps a sticky flag until a status read.
// Assumes rx_valid is a single-cycle strobe per character.
module xfc_char_match
    import xfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [1:0]        wlen,
    input  logic [CHAR_W-1:0] cmp_val,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic              clr,
    output logic              flag
);
    logic [CHAR_W-1:0] mask;
    logic              hit;

    // Masked equality of the received character against the compare value
    always_comb begin
        mask = word_mask(wlen);
        hit  = enable && rx_valid && (((rx_char ^ cmp_val) & mask) == '0);
    end

    // Sticky flag: a new hit wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (hit) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end
endmodule

// File: rtl/xfc_insert_seq.sv
// Module: four-state sequencer that offers the Xoff or Xon character pair
// to the transmitter and remembers that Xoff was sent last.
// Assumes the transmitter holds normal data while ins_req is high.
module xfc_insert_seq
    import xfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              allowed,
    input  logic              above,
    input  logic              below,
    input  logic [CHAR_W-1:0] xon1,
    input  logic [CHAR_W-1:0] xon2,
    input  logic [CHAR_W-1:0] xoff1,
    input  logic [CHAR_W-1:0] xoff2,
    input  logic              ack,
    output logic              req,
    output logic [CHAR_W-1:0] chr
);
    seq_state_t state;
    pair_kind_t kind;

    // State and pair-kind update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            kind  <= PAIR_XON;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (allowed && above) begin
                        state <= SEQ_FIRST;
                        kind  <= PAIR_XOFF;
                    end
                end
                SEQ_FIRST: begin
                    if (ack) state <= SEQ_SECOND;
                end
                SEQ_SECOND: begin
                    if (ack) state <= (kind == PAIR_XOFF) ? SEQ_OFF : SEQ_IDLE;
                end
                SEQ_OFF: begin
                    if (!allowed) begin
                        state <= SEQ_IDLE;
                    end else if (below) begin
                        state <= SEQ_FIRST;
                        kind  <= PAIR_XON;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // Handshake outputs decoded from the state and pair kind
    always_comb begin
        req = (state == SEQ_FIRST) || (state == SEQ_SECOND);
        chr = '0;
        if (state == SEQ_FIRST)
            chr = (kind == PAIR_XOFF) ? xoff1 : xon1;
        else if (state == SEQ_SECOND)
            chr = (kind == PAIR_XOFF) ? xoff2 : xon2;
    end
endmodule

// File: rtl/xonxoff_flow_ctrl.sv
// Module: top of the Xon/Xoff flow controller. Joins the level comparator,
// the pair sequencer and the special-character matcher.
// Assumes rx_level is the receive FIFO count of a DEPTH-entry FIFO.
module xonxoff_flow_ctrl
    import xfc_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flow_en,
    input  logic              special_en,
    input  logic [1:0]        wlen,
    input  logic [LVL_W-1:0]  trig_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [CHAR_W-1:0] xon1_char,
    input  logic [CHAR_W-1:0] xon2_char,
    input  logic [CHAR_W-1:0] xoff1_char,
    input  logic [CHAR_W-1:0] xoff2_char,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic              isr_read,
    input  logic              ins_ack,
    output logic              ins_req,
    output logic [CHAR_W-1:0] ins_char,
    output logic              special_flag
);
    logic lvl_above;
    logic lvl_below;
    logic flow_allowed;

    // Special-detect mode suppresses automatic insertion
    always_comb flow_allowed = flow_en && !special_en;

    xfc_level_cmp #(.LVL_W(LVL_W)) u_cmp (
        .level  (rx_level),
        .thresh (trig_level),
        .above  (lvl_above),
        .below  (lvl_below)
    );

    xfc_insert_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .allowed (flow_allowed),
        .above   (lvl_above),
        .below   (lvl_below),
        .xon1    (xon1_char),
        .xon2    (xon2_char),
        .xoff1   (xoff1_char),
        .xoff2   (xoff2_char),
        .ack     (ins_ack),
        .req     (ins_req),
        .chr     (ins_char)
    );

    xfc_char_match u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (special_en),
        .wlen     (wlen),
        .cmp_val  (xoff2_char),
        .rx_valid (rx_valid),
        .rx_char  (rx_char),
        .clr      (isr_read),
        .flag     (special_flag)
    );
endmodule

// File: rtl/xfc_checker.sv
// Module: property checker for the flow controller, bound to its top.
// Assumes it sees only the top-level ports.
module xfc_checker
    import xfc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              flow_en,
    input logic              special_en,
    input logic [1:0]        wlen,
    input logic [CHAR_W-1:0] xon1_char,
    input logic [CHAR_W-1:0] xoff1_char,
    input logic [CHAR_W-1:0] xoff2_char,
    input logic              rx_valid,
    input logic [CHAR_W-1:0] rx_char,
    input logic              isr_read,
    input logic              ins_ack,
    input logic              ins_req,
    input logic [CHAR_W-1:0] ins_char,
    input logic              special_flag
);
    logic rx_hit;
    always_comb rx_hit = special_en && rx_valid &&
                         (((rx_char ^ xoff2_char) & word_mask(wlen)) == '0);

    // R5: an unacknowledged offer stays up with the same character
    assert_hold_offer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ins_req && !ins_ack |=> ins_req && $stable(ins_char));

    // R6: a pair only begins when flow control was active
    assert_start_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ins_req) |-> $past(flow_en && !special_en));

    // R2: a pair opens with a first character (Xoff1 or Xon1)
    assert_first_char_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ins_req) |-> (ins_char == xoff1_char || ins_char == xon1_char));

    // R8: a masked match sets the flag
    assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_hit |=> special_flag);

    // R8: a status read without a new match clears the flag
    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        isr_read && !rx_hit |=> !special_flag);

    // R9: nothing sets the flag while detection is off
    assert_flag_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !special_flag && !special_en |=> !special_flag);
endmodule

bind xonxoff_flow_ctrl xfc_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flow_en      (flow_en),
    .special_en   (special_en),
    .wlen         (wlen),
    .xon1_char    (xon1_char),
    .xoff1_char   (xoff1_char),
    .xoff2_char   (xoff2_char),
    .rx_valid     (rx_valid),
    .rx_char      (rx_char),
    .isr_read     (isr_read),
    .ins_ack      (ins_ack),
    .ins_req      (ins_req),
    .ins_char     (ins_char),
    .special_flag (special_flag)
);

// File: tb/sim_xonxoff_flow_ctrl.sv
// Directed bench for the Xon/Xoff flow controller. Inputs change and
// outputs are sampled on the falling edge.
module sim_xonxoff_flow_ctrl;
    localparam int LVL_W = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flow_en = 1'b1;
    logic       special_en = 1'b0;
    logic [1:0] wlen = 2'b11;
    logic [LVL_W-1:0] trig_level = 6'd16;
    logic [LVL_W-1:0] rx_level = '0;
    logic [7:0] xon1_char = 8'h11;
    logic [7:0] xon2_char = 8'h51;
    logic [7:0] xoff1_char = 8'h13;
    logic [7:0] xoff2_char = 8'h93;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_char = '0;
    logic       isr_read = 1'b0;
    logic       ins_ack = 1'b0;
    logic       ins_req;
    logic [7:0] ins_char;
    logic       special_flag;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    xonxoff_flow_ctrl #(.DEPTH(32)) u0 (
        .clk(clk), .rst_n(rst_n), .flow_en(flow_en), .special_en(special_en),
        .wlen(wlen), .trig_level(trig_level), .rx_level(rx_level),
        .xon1_char(xon1_char), .xon2_char(xon2_char),
        .xoff1_char(xoff1_char), .xoff2_char(xoff2_char),
        .rx_valid(rx_valid), .rx_char(rx_char), .isr_read(isr_read),
        .ins_ack(ins_ack), .ins_req(ins_req), .ins_char(ins_char),
        .special_flag(special_flag)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Walks a pair already requested at this falling edge through the handshake
    task automatic run_pair(input logic [7:0] c1, input logic [7:0] c2, input string tag);
        chk(8'(ins_req), 8'd1, {tag, " req up"});
        chk(ins_char, c1, {tag, " first char"});
        @(negedge clk);
        chk(ins_char, c1, {tag, " first held without ack"});
        ins_ack = 1'b1;
        @(negedge clk);
        chk(8'(ins_req), 8'd1, {tag, " req during second"});
        chk(ins_char, c2, {tag, " second char"});
        @(negedge clk);
        ins_ack = 1'b0;
        chk(8'(ins_req), 8'd0, {tag, " req drops after pair"});
    endtask

    task automatic quiet(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(8'(ins_req), 8'd0, tag);
        end
    endtask

    task automatic send_char(input logic [7:0] c);
        rx_char = c;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(8'(ins_req), 8'd0, "R1 req in reset");
        chk(8'(special_flag), 8'd0, "R1 flag in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(8'(ins_req), 8'd0, "R1 req after reset");
        chk(8'(special_flag), 8'd0, "R1 flag after reset");
    endtask

    task automatic t_xoff_xon();
        rx_level = 6'd20;
        @(negedge clk);
        run_pair(8'h13, 8'h93, "R2 xoff");
        quiet(4, "R4 no repeat while above");
        rx_level = 6'd16;
        quiet(3, "R4 equal level holds");
        rx_level = 6'd10;
        @(negedge clk);
        run_pair(8'h11, 8'h51, "R3 xon");
        rx_level = 6'd16;
        quiet(3, "R4 equal level starts nothing");
    endtask

    task automatic t_uninterrupted();
        rx_level = 6'd25;
        @(negedge clk);
        chk(8'(ins_req), 8'd1, "R5 req up");
        rx_level = 6'd0;
        flow_en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(8'(ins_req), 8'd1, "R5 req held");
            chk(ins_char, 8'h13, "R5 first char held");
        end
        ins_ack = 1'b1;
        @(negedge clk);
        chk(ins_char, 8'h93, "R5 second char follows");
        @(negedge clk);
        ins_ack = 1'b0;
        chk(8'(ins_req), 8'd0, "R5 pair done");
        quiet(3, "R6 disabled no xon");
        flow_en = 1'b1;
        quiet(3, "R6 returned to idle no xon");
    endtask

    task automatic t_special_blocks();
        special_en = 1'b1;
        rx_level = 6'd30;
        quiet(4, "R6 special mode blocks xoff");
        special_en = 1'b0;
        @(negedge clk);
        run_pair(8'h13, 8'h93, "R2 xoff after special off");
        rx_level = 6'd2;
        @(negedge clk);
        run_pair(8'h11, 8'h51, "R3 xon recovery");
    endtask

    task automatic t_match();
        flow_en = 1'b0;
        special_en = 1'b0;
        wlen = 2'b11;
        send_char(8'h93);
        chk(8'(special_flag), 8'd0, "R9 no detect when disabled");
        special_en = 1'b1;
        send_char(8'h92);
        chk(8'(special_flag), 8'd0, "R7 8-bit mismatch");
        send_char(8'h93);
        chk(8'(special_flag), 8'd1, "R8 8-bit match sets flag");
        repeat (3) @(negedge clk);
        chk(8'(special_flag), 8'd1, "R8 flag sticky");
        isr_read = 1'b1;
        @(negedge clk);
        isr_read = 1'b0;
        chk(8'(special_flag), 8'd0, "R8 flag cleared by read");
        wlen = 2'b00;
        send_char(8'hF3);
        chk(8'(special_flag), 8'd1, "R7 5-bit ignores upper bits");
        isr_read = 1'b1;
        @(negedge clk);
        isr_read = 1'b0;
        send_char(8'h12);
        chk(8'(special_flag), 8'd0, "R7 5-bit low bit differs");
        wlen = 2'b01;
        send_char(8'hD3);
        chk(8'(special_flag), 8'd1, "R7 6-bit match");
        isr_read = 1'b1;
        @(negedge clk);
        isr_read = 1'b0;
        wlen = 2'b10;
        send_char(8'h53);
        chk(8'(special_flag), 8'd0, "R7 7-bit bit6 differs");
        isr_read = 1'b1;
        send_char(8'h13);
        isr_read = 1'b0;
        chk(8'(special_flag), 8'd1, "R8 set wins over read");
        special_en = 1'b0;
        isr_read = 1'b1;
        @(negedge clk);
        isr_read = 1'b0;
        send_char(8'h93);
        chk(8'(special_flag), 8'd0, "R9 disabled after clear");
    endtask

    initial begin
        t_reset();
        t_xoff_xon();
        t_uninterrupted();
        t_special_blocks();
        t_match();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule